// File: doc/BRIEF.md
# DS3 FEAC Code Transmitter

This block sends far-end alarm and control codes on the outbound DS3 stream. The host loads a six-bit code into the code register. It then writes the control register with the enable bit and the start bit both set. The block wraps the code into a 16-bit codeword. It presents one codeword bit per frame, advancing each time the framer pulses the frame strobe to show that the FEAC slot of the current frame has been taken. The codeword goes out ten times back to back, which takes 160 frames.

A busy status bit stays high for the whole run. When the last bit of the tenth copy has gone, busy falls and a sticky interrupt status bit is set. The interrupt pin is that status gated by an interrupt-enable bit. Whenever no message is in flight, the FEAC bit is held at 1. The far end reads this as idle, and it lasts until the host issues the next start. The register interface is a simple one-cycle write/read port with a combinational read path.

Top module: `feac_tx`

## Requirements
- R1: The codeword is the 16-bit vector {0, c[5:0], 0, 8'hFF}. It is sent from its most significant bit down, so the bits leave as 0, c5 first through c0 last, 0, then eight 1s.
- R2: The bit position advances only on a cycle with frame_stb high. In each such cycle, feac_bit shows the bit for that frame, and cycles without the strobe leave it unchanged.
- R3: An accepted start sends the codeword exactly ten times in a row, 160 strobes in all. After that, every strobe carries 1.
- R4: Bit 0 of the control register (address 1) reads busy. Busy reads 1 from the cycle after an accepted start until the strobe that carries the last bit of the tenth copy, and 0 after that.
- R5: Completion sets the sticky interrupt status at control bit 4. The status stays set until a read of address 1, which clears it on that read's clock edge. feac_irq is high only when the status is set and the interrupt-enable bit (control bit 3) is 1.
- R6: While busy is 0, feac_bit is 1.
- R7: A start (control bit 2, write-only, reads 0) is accepted only when the same write also sets enable (control bit 1) and busy is 0. A start while busy, or with enable 0, has no effect on the sequence.
- R8: The code register (address 0, bits 5:0) takes a write only while busy is 0. Writes while busy are dropped.
- R9: Clearing enable during a sequence stops it. Busy drops to 0 within two cycles of the write, feac_bit returns to 1, and no interrupt status is set.
- R10: If a read of address 1 falls in the same cycle as the completing strobe, the read returns the old status (0, busy 1), and the status is left set afterwards.
- R11: After reset, both registers read 0, feac_bit is 1 and feac_irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears status on a control read) |
| host_addr | input | 1 | 0 = code register, 1 = control/status register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| frame_stb | input | 1 | Pulse per outbound frame: FEAC slot consumed |
| feac_bit | output | 1 | FEAC bit for the current frame |
| feac_irq | output | 1 | Completion interrupt |

## Verification
Two events can land on the same clock edge: the completing strobe sets the interrupt status, and a host read of the control register clears it. The bench drives the 160th strobe and a control read in one cycle. It expects the read to return busy set with the status still clear, and a later read to show the status set. A start and a code write placed in the middle of a running sequence are judged through the serial stream. The stream has to continue bit for bit unchanged, and the code read back afterwards must be the original value.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int CODE_W_DEF  = 6;
  localparam int CW_BITS_DEF = 16;
  localparam int REPEAT_DEF  = 10;
  localparam int DATA_W_DEF  = 8;
  // control/status register bit positions
  localparam int CTL_BUSY  = 0;
  localparam int CTL_EN    = 1;
  localparam int CTL_START = 2;
  localparam int CTL_IEN   = 3;
  localparam int CTL_ISTAT = 4;
endpackage

// File: rtl/feac_regs.sv
module feac_regs
  import feac_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              done,
  output logic [CODE_W-1:0] code_q,
  output logic              enable_q,
  output logic              start_pulse,
  output logic              irq
);

  logic [CODE_W-1:0] code_d;
  logic              enable_d, ien_q, ien_d, stat_q, stat_d;
  logic              ctl_wr, ctl_rd;

  assign ctl_wr = wr && addr;
  assign ctl_rd = rd && addr;

  always_comb begin
    code_d   = code_q;
    enable_d = enable_q;
    ien_d    = ien_q;
    stat_d   = stat_q;
    if (wr && !addr && !busy) code_d = wdata[CODE_W-1:0];
    if (ctl_wr) begin
      enable_d = wdata[CTL_EN];
      ien_d    = wdata[CTL_IEN];
    end
    // completion wins over a read-clear in the same cycle
    if (done)        stat_d = 1'b1;
    else if (ctl_rd) stat_d = 1'b0;
  end

  assign start_pulse = ctl_wr && wdata[CTL_START] && wdata[CTL_EN] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      enable_q <= 1'b0;
      ien_q    <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      code_q   <= code_d;
      enable_q <= enable_d;
      ien_q    <= ien_d;
      stat_q   <= stat_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr) begin
      rdata[CODE_W-1:0] = code_q;
    end else begin
      rdata[CTL_BUSY]  = busy;
      rdata[CTL_EN]    = enable_q;
      rdata[CTL_IEN]   = ien_q;
      rdata[CTL_ISTAT] = stat_q;
    end
  end

  assign irq = stat_q && ien_q;

  assert_code_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(code_q));
  assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> stat_q);
  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !ctl_rd) |=> stat_q);

endmodule

// File: rtl/feac_seq.sv
module feac_seq #(
  parameter int CW_BITS = 16,
  parameter int REPEATS = 10,
  localparam int BIT_W  = $clog2(CW_BITS),
  localparam int REP_W  = $clog2(REPEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             frm_stb,
  output logic             busy,
  output logic [BIT_W-1:0] bit_idx,
  output logic             done
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CW_BITS - 1);
  localparam logic [REP_W-1:0] LAST_REP = REP_W'(REPEATS - 1);

  logic             busy_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             advance, last_bit, last_rep;

  assign advance  = busy && enable && frm_stb;
  assign last_bit = (bit_q == LAST_BIT);
  assign last_rep = (rep_q == LAST_REP);
  assign done     = advance && last_bit && last_rep;

  always_comb begin
    busy_d = busy;
    bit_d  = bit_q;
    rep_d  = rep_q;
    if (start && !busy) begin
      busy_d = 1'b1;
      bit_d  = '0;
      rep_d  = '0;
    end else if (!enable) begin
      busy_d = 1'b0;
      bit_d  = '0;
      rep_d  = '0;
    end else if (advance) begin
      if (!last_bit) begin
        bit_d = bit_q + 1'b1;
      end else begin
        bit_d = '0;
        if (last_rep) begin
          busy_d = 1'b0;
          rep_d  = '0;
        end else begin
          rep_d = rep_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      bit_q <= '0;
      rep_q <= '0;
    end else begin
      busy  <= busy_d;
      bit_q <= bit_d;
      rep_q <= rep_d;
    end
  end

  assign bit_idx = bit_q;

  assert_hold_off_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable && !frm_stb) |=> ($stable(bit_q) && $stable(rep_q)));
  assert_end_after_tenth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable && frm_stb && last_bit && last_rep) |=> !busy);
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !start) |=> !busy);
  assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

// File: rtl/feac_serializer.sv
module feac_serializer #(
  parameter int CODE_W  = 6,
  parameter int CW_BITS = 16,
  localparam int BIT_W  = $clog2(CW_BITS),
  localparam int TAIL   = CW_BITS - CODE_W - 2
) (
  input  logic [CODE_W-1:0] code,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              busy,
  output logic              ser_out
);

  logic [CW_BITS-1:0] cw;
  logic [CW_BITS-1:0] send_order;

  assign cw = {1'b0, code, 1'b0, {TAIL{1'b1}}};

  // send_order[k] is the k-th bit to leave: codeword MSB first
  for (genvar k = 0; k < CW_BITS; k++) begin : g_order
    assign send_order[k] = cw[CW_BITS-1-k];
  end

  assign ser_out = busy ? send_order[bit_idx] : 1'b1;

endmodule

// File: rtl/feac_tx.sv
module feac_tx
  import feac_pkg::*;
#(
  parameter int CODE_W  = CODE_W_DEF,
  parameter int CW_BITS = CW_BITS_DEF,
  parameter int REPEATS = REPEAT_DEF,
  parameter int DATA_W  = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              frame_stb,
  output logic              feac_bit,
  output logic              feac_irq
);

  localparam int BIT_W = $clog2(CW_BITS);

  logic              rst_m, rst_s;
  logic [CODE_W-1:0] code_q;
  logic              enable_q, start_pulse, busy, done;
  logic [BIT_W-1:0]  bit_idx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  feac_regs #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr(host_wr), .rd(host_rd), .addr(host_addr),
    .wdata(host_wdata), .rdata(host_rdata), .busy(busy), .done(done),
    .code_q(code_q), .enable_q(enable_q), .start_pulse(start_pulse), .irq(feac_irq)
  );

  feac_seq #(.CW_BITS(CW_BITS), .REPEATS(REPEATS)) u_seq (
    .clk(clk), .rst_n(rst_s), .enable(enable_q), .start(start_pulse),
    .frm_stb(frame_stb), .busy(busy), .bit_idx(bit_idx), .done(done)
  );

  feac_serializer #(.CODE_W(CODE_W), .CW_BITS(CW_BITS)) u_ser (
    .code(code_q), .bit_idx(bit_idx), .busy(busy), .ser_out(feac_bit)
  );

  assert_idle_ones_R6: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> feac_bit);
  assert_no_irq_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(feac_irq) |-> !busy);

endmodule

// File: tb/test_feac_tx.sv
module test_feac_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       frame_stb = 1'b0;
  logic       feac_bit, feac_irq;

  int n_chk = 0, n_fail = 0;
  logic exp_q[$];
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  feac_tx i_feac_tx (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_stb(frame_stb), .feac_bit(feac_bit), .feac_irq(feac_irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: each consumed frame slot must carry the next expected bit (R1 R2 R3)
  always @(negedge clk) begin
    if (frame_stb) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3: strobe with nothing expected, actual %b expected none", feac_bit);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (feac_bit !== e) begin
          n_fail++;
          $display("FAIL R1: serial bit actual %b expected %b", feac_bit, e);
        end
      end
    end
  end

  task automatic push_message(logic [5:0] code);
    logic [15:0] cw;
    cw = {1'b0, code, 1'b0, 8'hFF};
    for (int r = 0; r < 10; r++)
      for (int b = 15; b >= 0; b--) exp_q.push_back(cw[b]);
  endtask

  task automatic push_idle(int n);
    for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(posedge clk); #2;
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #2;
    host_wr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(posedge clk); #2;
    host_rd = 1'b1; host_addr = a;
    @(negedge clk); d = host_rdata;
    @(posedge clk); #2;
    host_rd = 1'b0;
  endtask

  task automatic strobes(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; frame_stb = 1'b1;
      @(posedge clk); #2; frame_stb = 1'b0;
      for (int g = 0; g < gap; g++) @(posedge clk);
    end
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle_cycles(3);
    #2 rst_n = 1'b1;
    idle_cycles(4);

    // R11 reset state
    rd(1'b0, rv); check("R11 code", rv, 8'h00);
    rd(1'b1, rv); check("R11 ctrl", rv, 8'h00);
    check("R11 feac_bit", {7'b0, feac_bit}, 8'h01);
    check("R11 irq", {7'b0, feac_irq}, 8'h00);
    push_idle(2); strobes(2, 0);                   // R6 idle before any start

    // main message with gaps, busy-time start and code write ignored
    wr(1'b0, 8'h2A);
    push_message(6'h2A);
    wr(1'b1, 8'h0E);                               // enable + start + ien
    rd(1'b1, rv); check("R4 busy set", rv, 8'h0B);
    strobes(80, 1);                                // R2 gaps between strobes
    wr(1'b1, 8'h0E);                               // R7 start while busy ignored
    wr(1'b0, 8'h3F);                               // R8 write while busy dropped
    check("R5 no irq mid-run", {7'b0, feac_irq}, 8'h00);
    strobes(80, 0);
    check("R5 irq raised", {7'b0, feac_irq}, 8'h01);
    rd(1'b1, rv); check("R4/R5 done status", rv, 8'h1A);
    rd(1'b1, rv); check("R5 read clears", rv, 8'h0A);
    check("R5 irq cleared", {7'b0, feac_irq}, 8'h00);
    rd(1'b0, rv); check("R8 code kept", rv, 8'h2A);
    push_idle(20); strobes(20, 2);                 // R3 R6 idle after run

    // R7 start without enable
    wr(1'b1, 8'h04);
    rd(1'b1, rv); check("R7 start w/o enable", rv, 8'h00);
    push_idle(5); strobes(5, 0);

    // R9 abort
    wr(1'b0, 8'h15);
    wr(1'b1, 8'h0E);
    push_message(6'h15);
    strobes(20, 0);
    exp_q.delete();
    wr(1'b1, 8'h08);
    idle_cycles(2);
    rd(1'b1, rv); check("R9 abort ctrl", rv, 8'h08);
    check("R9 abort bit", {7'b0, feac_bit}, 8'h01);
    check("R9 abort irq", {7'b0, feac_irq}, 8'h00);
    push_idle(10); strobes(10, 0);

    // R5 interrupt disabled: status set, pin low
    wr(1'b0, 8'h3F);
    wr(1'b1, 8'h06);
    push_message(6'h3F);
    strobes(160, 0);
    check("R5 masked irq", {7'b0, feac_irq}, 8'h00);
    rd(1'b1, rv); check("R5 masked status", rv, 8'h12);
    rd(1'b1, rv); check("R5 masked clear", rv, 8'h02);

    // R10 completion and read-clear in one cycle
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h0E);
    push_message(6'h01);
    strobes(159, 0);
    @(posedge clk); #2;
    frame_stb = 1'b1; host_rd = 1'b1; host_addr = 1'b1;
    @(negedge clk); rv = host_rdata;
    @(posedge clk); #2;
    frame_stb = 1'b0; host_rd = 1'b0;
    check("R10 same-cycle read", rv, 8'h0B);
    check("R10 irq kept", {7'b0, feac_irq}, 8'h01);
    rd(1'b1, rv); check("R10 status kept", rv, 8'h1A);
    push_idle(4); strobes(4, 0);

    idle_cycles(2);
    check("R3 queue drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule